// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a single-clock static RAM of 32-bit words, built from four 8-bit byte lanes. On every rising clock edge it captures the address, the write data, three chip-select pins and the write-control pins into registers. A write can update any subset of the four lanes. It does this through per-lane strobes that count only while a separate byte-write enable is asserted, or it updates the whole word through a global write pin that overrides the lane strobes. A write needs no external pulse. The memory update happens on the edge after capture, using the registered values.

Reads are pipelined. The address is registered on the capture edge. The array output is registered on the next edge, and the word then drives `rdData`. The external pad shares one path for data in and data out. For that reason the block exposes `qDrive`, which tells the pad when to drive. `qDrive` is low during write cycles and while the device is deselected, and `rdData` is forced to zero whenever `qDrive` is low. A burst address generator, if the system needs one, sits outside this block and feeds `addr`.

Top module: `pipeSram`

## Requirements
- R1: All inputs are sampled on the rising clock edge. The word stored at the address sampled on a read edge appears on `rdData`, with `qDrive` high, after the following rising edge. That is two edges counting the capture edge.
- R2: The device is selected only when `sel0N` is low, `sel1` is high and `sel2N` is low. If any one of the three is inactive, the cycle does nothing.
- R3: With `globalWrN` high and `byteWrEnN` low, lane i (bits 8i+7 down to 8i, lane 0 being bits 7:0) is written exactly when `laneWrN[i]` is low. All other lanes keep their old contents.
- R4: With `globalWrN` low, all four lanes are written, whatever `byteWrEnN` and `laneWrN` hold.
- R5: A selected cycle with both `globalWrN` and `byteWrEnN` high is a read. A read changes no stored data, and `laneWrN` has no effect in that cycle.
- R6: A selected cycle with `globalWrN` low or `byteWrEnN` low is a write cycle, even if no lane strobe is low. Two edges after its capture, `qDrive` is low and `rdData` is zero.
- R7: A deselected cycle writes nothing. Two edges after its capture, `qDrive` is low and `rdData` is zero.
- R8: A read of an address in the cycle right after a write to that address returns the newly written bytes.
- R9: While `rstN` is low, `qDrive` is low and `rdData` is zero. A write that was captured but not yet committed when reset asserts is discarded. Stored data is not cleared by reset.
- R10: Reads issued on consecutive cycles return one word per cycle, in issue order, each from its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr | input | ADDR_W | Word address |
| wrData | input | 32 | Write data, four byte lanes |
| sel0N | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2N | input | 1 | Chip select, active low |
| globalWrN | input | 1 | Active-low write of all four lanes |
| byteWrEnN | input | 1 | Active-low qualifier for the lane strobes |
| laneWrN | input | 4 | Active-low per-lane write strobes, bit i for lane i |
| rdData | output | 32 | Read word, zero while not driven |
| qDrive | output | 1 | High when the pad should drive `rdData` |

## Verification
A corrupted lane mask or a stuck select decode does not show up in the cycle of the bad write. It surfaces on the first later read of the affected address, as wrong bytes in exactly the mis-handled lanes. The bench therefore reads back after every write and checks all four lanes. A wrong pipeline length or a wrong read/write classification shows at the ports within two edges, as `qDrive` asserting in the wrong cycle or a word arriving one cycle off. Streams of back-to-back reads and reads right after writes expose that at once.

// File: rtl/pipeSramPkg.sv
package pipeSramPkg;
  parameter int LANES_P  = 4;
  parameter int LANE_W_P = 8;
  localparam int WORD_W_P = LANES_P * LANE_W_P;

  // Strobes handed from the control stage to the datapath
  typedef struct packed {
    logic               wrEn;
    logic               rdEn;
    logic [LANES_P-1:0] laneMask;
  } strobeT;
endpackage

// File: rtl/pipeSramCtrl.sv
module pipeSramCtrl
  import pipeSramPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sel0N,
  input  logic               sel1,
  input  logic               sel2N,
  input  logic               globalWrN,
  input  logic               byteWrEnN,
  input  logic [LANES_P-1:0] laneWrN,
  output strobeT             stage,
  output logic               qDrive
);
  logic   selected;
  logic   wrReq;
  strobeT nextStage;

  always_comb begin
    selected       = !sel0N && sel1 && !sel2N;
    wrReq          = !globalWrN || !byteWrEnN;
    nextStage.wrEn = selected && wrReq;
    nextStage.rdEn = selected && !wrReq;
  end

  for (genvar g = 0; g < LANES_P; g++) begin : gLane
    always_comb
      nextStage.laneMask[g] = selected && (!globalWrN || (!byteWrEnN && !laneWrN[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage  <= '0;
      qDrive <= 1'b0;
    end else begin
      stage  <= nextStage;
      qDrive <= stage.rdEn;
    end
  end

  // A driven output must come from a selected read captured two edges earlier
  assert_drive_from_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    qDrive |-> $past(!sel0N && sel1 && !sel2N && globalWrN && byteWrEnN, 2));

  // Any inactive select releases the pad two edges later
  assert_deselect_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!sel0N && sel1 && !sel2N) |-> ##2 !qDrive);

  // A selected write cycle releases the pad two edges later
  assert_write_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!sel0N && sel1 && !sel2N && (!globalWrN || !byteWrEnN)) |-> ##2 !qDrive);

  // Global write covers every lane
  assert_global_all_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!sel0N && sel1 && !sel2N && !globalWrN) |=> (stage.wrEn && (&stage.laneMask)));

  // Lane strobes follow the pins only under the byte-write qualifier
  assert_lane_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!sel0N && sel1 && !sel2N && globalWrN && !byteWrEnN)
      |=> (stage.laneMask == ~$past(laneWrN)));
endmodule

// File: rtl/pipeSramData.sv
module pipeSramData
  import pipeSramPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stage,
  input  logic                qDrive,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W_P-1:0] wrData,
  output logic [WORD_W_P-1:0] rdData
);
  logic [ADDR_W-1:0]   addrQ;
  logic [WORD_W_P-1:0] dataQ;
  logic [WORD_W_P-1:0] outWord;

  always_ff @(posedge clk) begin
    addrQ <= addr;
    dataQ <= wrData;
  end

  for (genvar g = 0; g < LANES_P; g++) begin : gLane
    logic [LANE_W_P-1:0] laneMem [DEPTH];
    logic [LANE_W_P-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (stage.wrEn && stage.laneMask[g])
        laneMem[addrQ] <= dataQ[g*LANE_W_P +: LANE_W_P];
      if (stage.rdEn)
        laneOut <= laneMem[addrQ];
    end

    always_comb outWord[g*LANE_W_P +: LANE_W_P] = laneOut;
  end

  always_comb rdData = qDrive ? outWord : '0;

  // Lane strobes never appear outside a write
  assert_lane_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|stage.laneMask) |-> stage.wrEn);

  // A cycle is never both read and write
  assert_rd_wr_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stage.rdEn, stage.wrEn}));

  // The output word only moves after a read stage
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stage.rdEn |=> $stable(outWord));
endmodule

// File: rtl/pipeSram.sv
module pipeSram
  import pipeSramPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W_P-1:0] wrData,
  input  logic                sel0N,
  input  logic                sel1,
  input  logic                sel2N,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [LANES_P-1:0]  laneWrN,
  output logic [WORD_W_P-1:0] rdData,
  output logic                qDrive
);
  strobeT stage;

  pipeSramCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sel0N     (sel0N),
    .sel1      (sel1),
    .sel2N     (sel2N),
    .globalWrN (globalWrN),
    .byteWrEnN (byteWrEnN),
    .laneWrN   (laneWrN),
    .stage     (stage),
    .qDrive    (qDrive)
  );

  pipeSramData #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .stage  (stage),
    .qDrive (qDrive),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );

  // Reset keeps the pad released
  assert_reset_quiet_R9: assert property (@(posedge clk) !rstN |-> (!qDrive && rdData == '0));
endmodule

// File: tb/pipeSram_tb_top.sv
module pipeSram_tb_top;
  localparam int DEPTH = 16;
  localparam logic [2:0] SEL = 3'b010; // {sel0N, sel1, sel2N} all active

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        sel0N = 1'b1, sel1 = 1'b0, sel2N = 1'b1;
  logic        globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [3:0]  laneWrN = 4'hF;
  logic [31:0] rdData;
  logic        qDrive;

  int testsRun = 0;
  int testsFailed = 0;

  logic [31:0] model [DEPTH];
  logic        pValid [2];
  logic        pDrive [2];
  logic [31:0] pData  [2];
  string       pTag   [2];

  always #5 clk = ~clk;

  pipeSram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .sel0N(sel0N), .sel1(sel1), .sel2N(sel2N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .rdData(rdData), .qDrive(qDrive)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clearPipe();
    for (int i = 0; i < 2; i++) begin
      pValid[i] = 1'b0; pDrive[i] = 1'b0; pData[i] = '0; pTag[i] = "";
    end
  endtask

  // One cycle: check the op from two cycles back, then drive a new op
  task automatic cyc(input logic [3:0] a, input logic [31:0] d, input logic [2:0] sel,
                     input logic gw, input logic bwe, input logic [3:0] ln, input string tag);
    logic isSel, isWr;
    logic [3:0] mask;
    @(negedge clk);
    if (pValid[1]) begin
      check(pTag[1], "qDrive", {31'b0, qDrive}, {31'b0, pDrive[1]});
      check(pTag[1], "rdData", rdData, pDrive[1] ? pData[1] : 32'h0);
    end
    pValid[1] = pValid[0]; pDrive[1] = pDrive[0]; pData[1] = pData[0]; pTag[1] = pTag[0];
    {sel0N, sel1, sel2N} = sel;
    addr = a; wrData = d; globalWrN = gw; byteWrEnN = bwe; laneWrN = ln;
    isSel = (sel == SEL);
    isWr  = !gw || !bwe;
    mask  = !gw ? 4'hF : (!bwe ? ~ln : 4'h0);
    pValid[0] = 1'b1;
    pTag[0]   = tag;
    pDrive[0] = isSel && !isWr;
    pData[0]  = model[a];
    if (isSel && isWr)
      for (int l = 0; l < 4; l++)
        if (mask[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(4'h0, 32'h0, 3'b101, 1'b1, 1'b1, 4'hF, tag);
  endtask

  task automatic gwrite(input logic [3:0] a, input logic [31:0] d, input string tag);
    cyc(a, d, SEL, 1'b0, 1'b1, 4'hF, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(a, 32'hDEAD_BEEF, SEL, 1'b1, 1'b1, 4'h0, tag);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9", "qDrive in reset", {31'b0, qDrive}, 32'h0);
    check("R9", "rdData in reset", rdData, 32'h0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testGlobalWrite();
    for (int i = 0; i < DEPTH; i++) gwrite(i[3:0], 32'h1000_0000 * (i % 7) + 32'h0103_0507 * i, "R4");
    // Global write ignores the lane strobes and the byte qualifier
    cyc(4'd5, 32'hCAFE_F00D, SEL, 1'b0, 1'b0, 4'b1110, "R4");
    idle(1, "R7");
    for (int i = 0; i < DEPTH; i++) rd(i[3:0], "R1");
    idle(2, "R7");
  endtask

  task automatic testByteLanes();
    for (int p = 0; p < 16; p++) begin
      gwrite(4'd3, 32'h1122_3344, "R3");
      cyc(4'd3, 32'hAABB_CCDD ^ (32'h0101_0101 * p), SEL, 1'b1, 1'b0, p[3:0], "R3");
      rd(4'd3, "R3");
    end
    idle(2, "R7");
  endtask

  task automatic testReadKeeps();
    gwrite(4'd7, 32'h7777_0707, "R5");
    // Lane strobes low but qualifier high: a read, nothing written
    cyc(4'd7, 32'h0, SEL, 1'b1, 1'b1, 4'h0, "R5");
    rd(4'd7, "R5");
    idle(2, "R7");
  endtask

  task automatic testWriteNoLanes();
    gwrite(4'd8, 32'h8888_8888, "R6");
    cyc(4'd8, 32'h0, SEL, 1'b1, 1'b0, 4'hF, "R6");
    cyc(4'd8, 32'h0, SEL, 1'b1, 1'b0, 4'h0, "R6");
    rd(4'd8, "R6");
    idle(2, "R7");
  endtask

  task automatic testSelect();
    gwrite(4'd9, 32'h9999_0000, "R2");
    cyc(4'd9, 32'h1111_1111, 3'b110, 1'b0, 1'b1, 4'hF, "R2");
    cyc(4'd9, 32'h2222_2222, 3'b000, 1'b0, 1'b1, 4'hF, "R2");
    cyc(4'd9, 32'h3333_3333, 3'b011, 1'b0, 1'b1, 4'hF, "R2");
    cyc(4'd9, 32'h0, 3'b110, 1'b1, 1'b1, 4'hF, "R7");
    cyc(4'd9, 32'h0, 3'b011, 1'b1, 1'b1, 4'hF, "R7");
    rd(4'd9, "R2");
    idle(2, "R7");
  endtask

  task automatic testRaw();
    for (int i = 0; i < 4; i++) begin
      gwrite(4'd10 + i[3:0], 32'hA5A5_0000 + i, "R8");
      rd(4'd10 + i[3:0], "R8");
      cyc(4'd10 + i[3:0], 32'h00FF_EE00 + i, SEL, 1'b1, 1'b0, 4'b0101, "R8");
      rd(4'd10 + i[3:0], "R8");
    end
    idle(2, "R7");
  endtask

  task automatic testStream();
    for (int i = 0; i < 6; i++) gwrite(i[3:0], 32'h5EED_0000 | (i << 4), "R10");
    for (int i = 0; i < 6; i++) rd(i[3:0], "R10");
    for (int i = 5; i >= 0; i--) rd(i[3:0], "R10");
    idle(2, "R7");
  endtask

  task automatic testResetMidWrite();
    gwrite(4'd12, 32'h0C0C_0C0C, "R9");
    idle(2, "R7");
    @(negedge clk);
    {sel0N, sel1, sel2N} = SEL; addr = 4'd12; wrData = 32'hBAD0_BAD0;
    globalWrN = 1'b0; byteWrEnN = 1'b1; laneWrN = 4'hF;
    @(posedge clk); #2;
    rstN = 1'b0;
    {sel0N, sel1, sel2N} = 3'b101; globalWrN = 1'b1;
    @(negedge clk);
    check("R9", "qDrive during reset", {31'b0, qDrive}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    clearPipe();
    rd(4'd12, "R9");
    idle(2, "R7");
  endtask

  initial begin
    #(200000 * 10);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    clearPipe();
    testReset();
    testGlobalWrite();
    testByteLanes();
    testReadKeeps();
    testWriteNoLanes();
    testSelect();
    testRaw();
    testStream();
    testResetMidWrite();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule